// File: doc/BRIEF.md
# Multi-Port Blocking Write-Back Cache

This block is a small write-back data cache shared by several requesters and backed by one memory port. Every line can hold any memory block. A lookup compares the request tag against the tag of every line at once. The cache services exactly one access at a time. While that access is in flight, including any memory traffic it causes, all other requests are turned away. Each port that was turned away later gets a one-cycle retry strobe, which tells it the cache is free again.

Addresses are word addresses. The low bits select a word inside a line and the remaining bits form the tag, which is also the block number sent to memory. On a miss the cache first chooses a line. It takes the lowest-index invalid line if there is one, and otherwise a pseudo-random line taken from a free-running LFSR. If that line is dirty, it is written to memory as a whole. The full missing block is then read in, and the held access completes against the new line. The response goes back only on the port that issued the request.

Top module: `fa_wb_cache`

## Requirements
- R1: After reset no line is valid, both counters read zero, and no port sees accept, retry or response. The memory request is low.
- R2: A block may occupy any line, so up to NUM_LINES distinct blocks stay resident together, whatever their low tag bits are. A block is never held in two lines.
- R3: A read miss reads block `addr[ADDR_W-1:OFF_W]` from memory as one LINE_W transfer. Word k of the block is carried in bits `[k*DATA_W +: DATA_W]`. The held read then returns the word at offset `addr[OFF_W-1:0]` from the filled line.
- R4: A write changes only the cached line and marks it dirty. Memory sees the data only when that line is evicted. An eviction writes the whole line back before the fill read is issued.
- R5: While an invalid line exists, a miss fills an invalid line and evicts nothing. Once every line is valid, the victim is taken from an LFSR reduced modulo NUM_LINES.
- R6: The hit/miss decision comes LOOKUP_LAT cycles after acceptance, for hits and misses alike. A hit responds LOOKUP_LAT+1 cycles after the accepting edge.
- R7: Only one access is in flight. From acceptance until the response cycle, no request on any port is accepted.
- R8: A port that was refused receives a single-cycle `req_retry_o` strobe in the first idle cycle afterwards. A port that was never refused receives none.
- R9: When several ports request in the same idle cycle, the lowest index is accepted and the others are refused.
- R10: `rsp_valid_o` pulses for one cycle, only on the port that issued the access.
- R11: Each completed access increments exactly one of the hit counter or the miss counter.
- R12: The memory request holds its address, direction and data steady until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_PORTS | Per-port request strobe |
| req_write_i | input | NUM_PORTS | Per-port write (1) or read (0) |
| req_addr_i | input | NUM_PORTS*ADDR_W | Per-port word address, port p in slice p |
| req_wdata_i | input | NUM_PORTS*DATA_W | Per-port write data |
| req_accept_o | output | NUM_PORTS | Request taken this cycle |
| req_retry_o | output | NUM_PORTS | Cache free again after a refusal |
| rsp_valid_o | output | NUM_PORTS | Response on the issuing port |
| rsp_hit_o | output | 1 | Access of the current response hit |
| rsp_rdata_o | output | DATA_W | Read data of the current response |
| mem_req_o | output | 1 | Memory transfer pending |
| mem_write_o | output | 1 | Transfer is a write-back |
| mem_addr_o | output | TAG_W | Block number |
| mem_wdata_o | output | LINE_W | Write-back line |
| mem_ack_i | input | 1 | Transfer complete, read data valid |
| mem_rdata_i | input | LINE_W | Fill line |
| hit_count_o | output | CNT_W | Completed hits |
| miss_count_o | output | CNT_W | Completed misses |

## Verification
Two pairs of functions can land in the same cycle. Arbitration can pick one port and refuse another at the same edge. The retry strobe can also coincide with a new acceptance. The bench raises both ports on one falling edge and checks that only port 0 is accepted. It then holds port 1 and checks that, in the first idle cycle after port 0's response, port 1 sees its retry strobe and its acceptance together. A separate case refuses a port in the middle of a miss and checks that its strobe comes exactly one cycle after the other port's response, and only once.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_RESP
  } cache_state_e;
endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] value_o
);
  logic [W-1:0] s_q;
  logic         fb;

  assign fb      = s_q[W-1] ^ s_q[W-3] ^ s_q[W-4] ^ s_q[W-6];
  assign value_o = s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= SEED;
    else         s_q <= {s_q[W-2:0], fb};
  end

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_q != '0);
endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int LINES = 4,
  parameter int TAG_W = 6,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LINES-1:0]       valid_i,
  input  logic [LINES*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]       tag_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       hit_idx_o,
  output logic                   free_o,
  output logic [IDX_W-1:0]       free_idx_o
);
  logic [LINES-1:0] match;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    hit_o      = |match;
    free_o     = ~&valid_i;
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i])    hit_idx_o  = IDX_W'(i);
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  // R2
  dup_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/cache_port_arb.sv
module cache_port_arb #(
  parameter int PORTS = 2,
  parameter int PID_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic [PORTS-1:0] valid_i,
  output logic [PORTS-1:0] grant_o,
  output logic [PID_W-1:0] grant_idx_o,
  output logic [PORTS-1:0] retry_o
);
  logic [PORTS-1:0] pend_q;

  always_comb begin
    grant_o     = '0;
    grant_idx_o = '0;
    if (idle_i) begin
      for (int i = PORTS - 1; i >= 0; i--) begin
        if (valid_i[i]) begin
          grant_o     = '0;
          grant_o[i]  = 1'b1;
          grant_idx_o = PID_W'(i);
        end
      end
    end
  end

  assign retry_o = idle_i ? pend_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (idle_i ? '0 : pend_q) | (valid_i & ~grant_o);
  end

  // R9
  grant_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> ((valid_i & (grant_o - PORTS'(1))) == '0));
  // R8
  retry_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|retry_o) |=> ((retry_o & $past(retry_o) & ~$past(valid_i)) == '0));
endmodule

// File: rtl/fa_wb_cache.sv
module fa_wb_cache
  import fa_cache_pkg::*;
#(
  parameter int NUM_PORTS  = 2,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 4,
  parameter int LOOKUP_LAT = 2,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int LINE_W    = DATA_W * LINE_WORDS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        req_valid_i,
  input  logic [NUM_PORTS-1:0]        req_write_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] req_addr_i,
  input  logic [NUM_PORTS*DATA_W-1:0] req_wdata_i,
  output logic [NUM_PORTS-1:0]        req_accept_o,
  output logic [NUM_PORTS-1:0]        req_retry_o,
  output logic [NUM_PORTS-1:0]        rsp_valid_o,
  output logic                        rsp_hit_o,
  output logic [DATA_W-1:0]           rsp_rdata_o,
  output logic                        mem_req_o,
  output logic                        mem_write_o,
  output logic [TAG_W-1:0]            mem_addr_o,
  output logic [LINE_W-1:0]           mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic [LINE_W-1:0]           mem_rdata_i,
  output logic [CNT_W-1:0]            hit_count_o,
  output logic [CNT_W-1:0]            miss_count_o
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int PID_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int LAT_W = $clog2(LOOKUP_LAT + 1);
  localparam int RND_W = 16;

  cache_state_e state_q;
  logic [LAT_W-1:0]  lat_q;
  logic [PID_W-1:0]  port_q;
  logic              write_q, hit_q;
  logic [TAG_W-1:0]  tag_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  line_q;
  logic [CNT_W-1:0]  hit_cnt_q, miss_cnt_q;

  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]     tag_arr  [NUM_LINES];
  logic [LINE_W-1:0]    data_arr [NUM_LINES];
  logic [NUM_LINES*TAG_W-1:0] tags_flat;

  logic              idle;
  logic [PID_W-1:0]  grant_idx;
  logic [ADDR_W-1:0] sel_addr;
  logic              lk_hit, lk_free;
  logic [IDX_W-1:0]  lk_hit_idx, lk_free_idx, victim;
  logic [RND_W-1:0]  rnd;
  logic              decide;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_tags
    assign tags_flat[g*TAG_W +: TAG_W] = tag_arr[g];
  end

  assign idle = (state_q == ST_IDLE);

  cache_port_arb #(.PORTS(NUM_PORTS), .PID_W(PID_W)) i_arb (
    .clk_i, .rst_ni,
    .idle_i      (idle),
    .valid_i     (req_valid_i),
    .grant_o     (req_accept_o),
    .grant_idx_o (grant_idx),
    .retry_o     (req_retry_o)
  );

  cache_tag_match #(.LINES(NUM_LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_match (
    .clk_i, .rst_ni,
    .valid_i    (valid_q),
    .tags_i     (tags_flat),
    .tag_i      (tag_q),
    .hit_o      (lk_hit),
    .hit_idx_o  (lk_hit_idx),
    .free_o     (lk_free),
    .free_idx_o (lk_free_idx)
  );

  cache_lfsr #(.W(RND_W)) i_lfsr (
    .clk_i, .rst_ni,
    .value_o (rnd)
  );

  assign sel_addr = req_addr_i[grant_idx*ADDR_W +: ADDR_W];
  assign victim   = lk_free ? lk_free_idx : IDX_W'(rnd % RND_W'(NUM_LINES));
  assign decide   = (state_q == ST_LOOKUP) && (lat_q == LAT_W'(LOOKUP_LAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lat_q      <= '0;
      port_q     <= '0;
      write_q    <= 1'b0;
      hit_q      <= 1'b0;
      tag_q      <= '0;
      off_q      <= '0;
      wdata_q    <= '0;
      line_q     <= '0;
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
      valid_q    <= '0;
      dirty_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (|req_accept_o) begin
          port_q  <= grant_idx;
          write_q <= req_write_i[grant_idx];
          tag_q   <= sel_addr[ADDR_W-1:OFF_W];
          off_q   <= sel_addr[OFF_W-1:0];
          wdata_q <= req_wdata_i[grant_idx*DATA_W +: DATA_W];
          lat_q   <= '0;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (decide) begin
            if (lk_hit) begin
              line_q  <= lk_hit_idx;
              hit_q   <= 1'b1;
              state_q <= ST_RESP;
            end else begin
              line_q  <= victim;
              hit_q   <= 1'b0;
              state_q <= (valid_q[victim] && dirty_q[victim]) ? ST_WBACK : ST_FILL;
            end
          end else begin
            lat_q <= lat_q + LAT_W'(1);
          end
        end
        ST_WBACK: if (mem_ack_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) begin
          valid_q[line_q] <= 1'b1;
          dirty_q[line_q] <= 1'b0;
          state_q         <= ST_RESP;
        end
        ST_RESP: begin
          if (write_q) dirty_q[line_q] <= 1'b1;
          if (hit_q) hit_cnt_q  <= hit_cnt_q + CNT_W'(1);
          else       miss_cnt_q <= miss_cnt_q + CNT_W'(1);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // line storage, no reset needed: valid bits gate every use
  always_ff @(posedge clk_i) begin
    if (state_q == ST_FILL && mem_ack_i) begin
      data_arr[line_q] <= mem_rdata_i;
      tag_arr[line_q]  <= tag_q;
    end else if (state_q == ST_RESP && write_q) begin
      data_arr[line_q][off_q*DATA_W +: DATA_W] <= wdata_q;
    end
  end

  always_comb begin
    rsp_valid_o = '0;
    if (state_q == ST_RESP) rsp_valid_o[port_q] = 1'b1;
  end

  assign rsp_hit_o    = hit_q;
  assign rsp_rdata_o  = data_arr[line_q][off_q*DATA_W +: DATA_W];
  assign mem_req_o    = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_write_o  = (state_q == ST_WBACK);
  assign mem_addr_o   = (state_q == ST_WBACK) ? tag_arr[line_q] : tag_q;
  assign mem_wdata_o  = data_arr[line_q];
  assign hit_count_o  = hit_cnt_q;
  assign miss_count_o = miss_cnt_q;

  logic [CNT_W-1:0] cnt_sum;
  assign cnt_sum = hit_cnt_q + miss_cnt_q;

  // R7
  one_in_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_accept_o) |=> (req_accept_o == '0));
  // R10
  rsp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o));
  // R11
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rsp_valid_o) |=> (cnt_sum == $past(cnt_sum) + CNT_W'(1)));
  // R12
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_write_o)));
  // R4
  wb_then_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_write_o && mem_ack_i) |=> (mem_req_o && !mem_write_o));
endmodule

// File: tb/test_fa_wb_cache.sv
module test_fa_wb_cache;
  localparam int P   = 2;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [P-1:0]   req_valid = '0, req_write = '0;
  logic [P*8-1:0] req_addr = '0, req_wdata = '0;
  logic [P-1:0]   req_accept, req_retry, rsp_valid;
  logic           rsp_hit;
  logic [7:0]     rsp_rdata;
  logic           mem_req, mem_write;
  logic [5:0]     mem_addr;
  logic [31:0]    mem_wdata;
  logic           mem_ack = 1'b0;
  logic [31:0]    mem_rdata = '0;
  logic [15:0]    hit_count, miss_count;

  fa_wb_cache #(.NUM_PORTS(P), .LOOKUP_LAT(LAT)) i_fa_wb_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_accept_o(req_accept), .req_retry_o(req_retry),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_write_o(mem_write), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .hit_count_o(hit_count), .miss_count_o(miss_count)
  );

  int total = 0, bad = 0, cyc = 0;
  int n_fill = 0, n_wb = 0, n_rsp = 0, n_hit = 0, mem_wait = 0;
  bit done = 1'b0;
  logic [7:0]  golden [256];
  logic [31:0] bmem   [64];

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
    end
  end

  // response tally for the counter checks
  always @(negedge clk) if (rst_n && |rsp_valid) begin
    n_rsp++;
    if (rsp_hit) n_hit++;
  end

  // memory model: ack two cycles after request, check write-back content
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        mem_wait = 0;
      end else if (rst_n && mem_req) begin
        mem_wait++;
        if (mem_wait == 2) begin
          mem_ack = 1'b1;
          if (mem_write) begin
            logic [31:0] expv;
            for (int k = 0; k < 4; k++) expv[k*8 +: 8] = golden[mem_addr*4 + k];
            // R4 evicted dirty line carries all completed writes
            chk(mem_wdata == expv, "R4", "writeback line", int'(mem_wdata), int'(expv));
            bmem[mem_addr] = mem_wdata;
            n_wb++;
          end else begin
            mem_rdata = bmem[mem_addr];
            n_fill++;
          end
        end
      end
    end
  end

  task automatic access(input int p, input bit wr, input logic [7:0] a,
                        input logic [7:0] wd, output logic [7:0] rd,
                        output bit hit, output int lat);
    int f0;
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_write[p] = wr;
    req_addr[p*8 +: 8] = a;
    req_wdata[p*8 +: 8] = wd;
    #1;
    while (!req_accept[p]) begin
      @(negedge clk);
      #1;
    end
    f0 = n_fill;
    lat = 0;
    @(negedge clk);
    req_valid[p] = 1'b0;
    #1;
    lat = 1;
    while (!rsp_valid[p]) begin
      @(negedge clk);
      #1;
      lat++;
    end
    // R10 response only on issuing port
    chk(rsp_valid == (P'(1) << p), "R10", "rsp port", int'(rsp_valid), 1 << p);
    rd = rsp_rdata;
    hit = rsp_hit;
    // R3 a miss performs exactly one fill; a hit none
    chk(hit == (n_fill == f0), "R3", "hit vs fill", int'(hit), int'(n_fill == f0));
    if (hit) chk(lat == LAT + 1, "R6", "hit latency", lat, LAT + 1);
    else     chk(lat > LAT + 1, "R6", "miss latency", lat, LAT + 2);
    if (!wr) chk(rd == golden[a], "R3", "read data", int'(rd), int'(golden[a]));
    else golden[a] = wd;
  endtask

  initial begin
    logic [7:0] rd;
    bit hit;
    int lat;
    int wb0;
    bit seen;
    for (int a = 0; a < 256; a++) golden[a] = init_val(a);
    for (int b = 0; b < 64; b++)
      for (int k = 0; k < 4; k++) bmem[b][k*8 +: 8] = init_val(b * 4 + k);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(hit_count == 0 && miss_count == 0, "R1", "counters", int'(hit_count), 0);
    chk(!mem_req, "R1", "mem_req", int'(mem_req), 0);
    chk(req_retry == 0 && rsp_valid == 0 && req_accept == 0, "R1", "port strobes",
        int'({req_retry, rsp_valid, req_accept}), 0);

    // R2 R5: four blocks sharing low tag bits all fill free lines
    access(0, 0, 8'h10, 0, rd, hit, lat);
    chk(!hit, "R1", "cold miss", int'(hit), 0);
    access(1, 0, 8'h50, 0, rd, hit, lat);
    chk(!hit, "R2", "miss 0x50", int'(hit), 0);
    access(0, 0, 8'h90, 0, rd, hit, lat);
    chk(!hit, "R2", "miss 0x90", int'(hit), 0);
    access(1, 0, 8'hD0, 0, rd, hit, lat);
    chk(!hit, "R2", "miss 0xD0", int'(hit), 0);
    chk(n_wb == 0, "R5", "no eviction while free", n_wb, 0);
    access(0, 0, 8'h13, 0, rd, hit, lat);
    chk(hit, "R2", "resident 0x13", int'(hit), 1);
    access(1, 0, 8'h52, 0, rd, hit, lat);
    chk(hit, "R2", "resident 0x52", int'(hit), 1);
    access(0, 0, 8'h91, 0, rd, hit, lat);
    chk(hit, "R5", "resident 0x91", int'(hit), 1);
    access(1, 0, 8'hD3, 0, rd, hit, lat);
    chk(hit, "R2", "resident 0xD3", int'(hit), 1);

    // R4 write hit stays in cache
    wb0 = n_wb;
    access(0, 1, 8'h51, 8'hC7, rd, hit, lat);
    chk(hit, "R4", "write hit", int'(hit), 1);
    chk(n_wb == wb0, "R4", "no writeback on write", n_wb, wb0);
    chk(bmem[20][15:8] == init_val(8'h51), "R4", "memory untouched",
        int'(bmem[20][15:8]), int'(init_val(8'h51)));
    access(1, 0, 8'h51, 0, rd, hit, lat);
    chk(rd == 8'hC7, "R4", "readback", int'(rd), 8'hC7);

    // R7 R8: refuse port 1 during a miss, then a single retry strobe
    fork
      access(0, 0, 8'h30, 0, rd, hit, lat);
      begin
        int gap;
        seen = 1'b0;
        gap = 0;
        do begin @(negedge clk); #2; end while (!req_accept[0]);
        @(negedge clk);
        req_valid[1] = 1'b1;
        req_write[1] = 1'b0;
        req_addr[15:8] = 8'h10;
        #2;
        chk(!req_accept[1], "R7", "busy refuse", int'(req_accept[1]), 0);
        @(negedge clk);
        #2;
        chk(req_retry == 0, "R8", "no retry while busy", int'(req_retry), 0);
        req_valid[1] = 1'b0;
        while (!req_retry[1]) begin
          @(negedge clk);
          #2;
          if (rsp_valid[0]) begin seen = 1'b1; gap = 0; end
          else gap++;
          chk(!req_retry[0], "R8", "never-refused port", int'(req_retry[0]), 0);
        end
        chk(seen && gap == 1, "R8", "retry after response", gap, 1);
        @(negedge clk);
        #2;
        chk(req_retry == 0, "R8", "retry is one pulse", int'(req_retry), 0);
      end
    join
    access(1, 0, 8'h10, 0, rd, hit, lat);

    // R9: same-cycle requests, lowest index wins, loser retried with accept
    @(negedge clk);
    req_valid = 2'b11;
    req_write = 2'b00;
    req_addr = {8'h12, 8'h31};
    #1;
    chk(req_accept == 2'b01, "R9", "lowest index", int'(req_accept), 1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    #1;
    while (!rsp_valid[0]) begin
      chk(rsp_valid[1] == 1'b0, "R10", "no stray rsp", int'(rsp_valid), 0);
      @(negedge clk);
      #1;
    end
    chk(rsp_rdata == golden[8'h31], "R9", "winner data", int'(rsp_rdata), int'(golden[8'h31]));
    @(negedge clk);
    #1;
    chk(req_retry[1] && req_accept[1], "R8", "retry with accept",
        int'({req_retry[1], req_accept[1]}), 3);
    @(negedge clk);
    req_valid[1] = 1'b0;
    #1;
    while (!rsp_valid[1]) begin @(negedge clk); #1; end
    chk(rsp_rdata == golden[8'h12], "R10", "loser data", int'(rsp_rdata), int'(golden[8'h12]));

    // sweep: mixed reads/writes over the whole space with evictions
    for (int i = 0; i < 256; i++) begin
      logic [7:0] a;
      a = 8'(i * 37 + 11);
      access(i % 2, (i % 3) == 0, a, 8'(i ^ 8'h5A), rd, hit, lat);
    end
    for (int a = 0; a < 256; a++) access(a % 2, 0, 8'(a), 0, rd, hit, lat);
    chk(n_wb > 0, "R4", "dirty evictions occurred", n_wb, 1);

    @(negedge clk);
    #1;
    // R11 counters
    chk(int'(hit_count) == n_hit, "R11", "hit count", int'(hit_count), n_hit);
    chk(int'(miss_count) == n_rsp - n_hit, "R11", "miss count", int'(miss_count), n_rsp - n_hit);
    chk(int'(miss_count) == n_fill, "R3", "misses equal fills", int'(miss_count), n_fill);
    done = 1'b1;
    summary();
  end
endmodule